// File: doc/BRIEF.md
# Symmetric Up-Down PWM Generator

This block produces one pulse-width-modulated output from a counter that climbs from zero to a programmable top value and then falls back to zero, repeating without a gap. Two compare channels (A and B) watch the counter. Each compare match is tagged by slope: rising or falling. The zero and top turnarounds are events too. An action stage turns these six events into drive-low, drive-high or toggle requests for the output. When several events land on one clock, the requests are resolved by a fixed priority.

Software uses a single write port to set the top value, the two compare values, the action word and a control word. The control word holds the run bit and picks the reload event for the compares. The compares are double-buffered. A write lands in a staging copy, and the staging copy moves to the working copy on the selected counter event. Because of this, a duty change never tears a period. With the usual setting (high on the rising-slope match, low on the falling-slope match), the duty range runs from 0% to 100% without any software help.

Top module: `updn_pwm`

## Requirements
- R1: While running, the counter goes up by one per clock from 0 to the top value, then down by one per clock back to 0. One full cycle takes 2×top clocks.
- R2: Each event has a 2-bit action code: 00 does nothing, 01 drives the output low, 10 drives it high, 11 inverts it.
- R3: The action word places the codes, from bit 0 upward, as zero [1:0], top [3:2], A rising [5:4], A falling [7:6], B rising [9:8], B falling [11:10]. Bits above 11 are ignored.
- R4: With A rising = high and A falling = low (action word 0x060), a compare A equal to the top value keeps the output high for the whole cycle.
- R5: With that setting and compare A = 0, the output is low for the whole cycle in steady state.
- R6: If running starts with the counter and compare A both at 0, the rising-slope match fires on the first running clock, and the output is high one clock later.
- R7: A compare value above the top never fires its rising-slope event. Its falling-slope event fires when the counter equals the top, so with word 0x060 the output stays low.
- R8: Written compare values wait in a staging copy. Control bit 1 = 0 moves them into use when the counter is 0. Control bit 1 = 1 moves them when the counter equals the top.
- R9: For simultaneous events, priority is B over A over top over zero. The highest-priority event with a non-zero code wins.
- R10: After reset the output is low. While control bit 0 (run) is low, the counter sits at 0 going up and the output keeps its last value.
- R11: With word 0x060 and 0 < C < top, the output is high for 2×(top−C) clocks of every 2×top-clock cycle.
- R12: Write addresses: 0 top value, 1 compare A, 2 compare B, 3 action word, 4 control (bit 0 run, bit 1 reload at top).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register select, see R12 |
| wr_data | input | CNT_W (16) | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with the default CNT_W of 16 and ADDR_W of 3. It programs top values between 5 and 10, so each vector reaches both turnarounds, and both reload points, within a few dozen clocks. Compare B is loaded with 0xFFFF wherever it is idle, which puts it on the beyond-top path. Checks that pit B against A, and A against the top event, reach the priority resolution. Pulse-width checks taken around a mid-cycle compare write show which reload point was used.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic [1:0] {
      ACT_NONE = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_TOG  = 2'b11
   } act_e;

   // event slots, lowest priority first
   localparam int EV_ZERO = 0;
   localparam int EV_TOP  = 1;
   localparam int EV_AU   = 2;
   localparam int EV_AD   = 3;
   localparam int EV_BU   = 4;
   localparam int EV_BD   = 5;
   localparam int N_EV    = 6;
   localparam int N_CMP   = 2;
   localparam int ACT_W   = 2 * N_EV;

   // write map
   localparam int ADR_TOP  = 0;
   localparam int ADR_CMP0 = 1;
   localparam int ADR_ACT  = 3;
   localparam int ADR_CTRL = 4;

   function automatic act_e act_field(input logic [ACT_W-1:0] w, input int idx);
      return act_e'(w[2*idx +: 2]);
   endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt,
   output logic             up,
   output logic             at_zero,
   output logic             at_top
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= ZERO;
         up  <= 1'b1;
      end else if (!run) begin
         cnt <= ZERO;
         up  <= 1'b1;
      end else if (up) begin
         if (cnt >= top) begin
            up  <= 1'b0;
            cnt <= (cnt == ZERO) ? ZERO : cnt - ONE;
         end else begin
            cnt <= cnt + ONE;
         end
      end else begin
         if (cnt == ZERO) begin
            up  <= 1'b1;
            cnt <= (top == ZERO) ? ZERO : ONE;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end

   assign at_zero = (cnt == ZERO);
   assign at_top  = (cnt == top);

   AST_CNT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && up && cnt < top) |=> cnt == $past(cnt) + ONE); // R1
   AST_CNT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !up && cnt != ZERO) |=> cnt == $past(cnt) - ONE); // R1
   AST_CNT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> (cnt == ZERO && up)); // R10

endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             load,
   input  logic             run,
   input  logic             up,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] top,
   output logic             ev_up,
   output logic             ev_dn
);

   logic [CNT_W-1:0] stage_q;
   logic [CNT_W-1:0] work_q;
   logic             beyond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         work_q  <= '0;
      end else begin
         if (wr)   stage_q <= wdata;
         if (load) work_q  <= stage_q;
      end
   end

   assign beyond = (work_q > top);
   assign ev_up  = run && up && !beyond && (cnt == work_q);
   assign ev_dn  = run && (beyond ? (cnt == top) : (!up && cnt == work_q));

   AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> work_q == $past(stage_q)); // R8
   AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(work_q)); // R8

endmodule

// File: rtl/pwm_act_qual.sv
module pwm_act_qual
   import pwm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EV-1:0]  ev,
   input  logic [ACT_W-1:0] act_word,
   output logic             pwm_out
);

   act_e win;
   logic nxt;

   always_comb begin
      win = ACT_NONE;
      for (int i = 0; i < N_EV; i++) begin
         if (ev[i] && act_field(act_word, i) != ACT_NONE) win = act_field(act_word, i);
      end
   end

   always_comb begin
      case (win)
         ACT_LOW:  nxt = 1'b0;
         ACT_HIGH: nxt = 1'b1;
         ACT_TOG:  nxt = ~pwm_out;
         default:  nxt = pwm_out;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_out <= 1'b0;
      else        pwm_out <= nxt;
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == '0) |=> $stable(pwm_out)); // R10
   AST_B_BEATS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[EV_BU] && act_field(act_word, EV_BU) == ACT_HIGH) |=> pwm_out); // R9
   AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == (N_EV'(1) << EV_ZERO) && act_field(act_word, EV_ZERO) == ACT_TOG)
      |=> pwm_out != $past(pwm_out)); // R2

endmodule

// File: rtl/updn_pwm.sv
module updn_pwm
   import pwm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic              pwm_out
);

   if (CNT_W < ACT_W || CNT_W > 32) begin : g_bad_width
      $error("updn_pwm: CNT_W must lie in 12..32");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("updn_pwm: ADDR_W must be at least 3");
   end

   logic [CNT_W-1:0] top_q;
   logic [ACT_W-1:0] act_q;
   logic             run_q;
   logic             ld_top_q;

   logic [CNT_W-1:0] cnt;
   logic             up;
   logic             at_zero;
   logic             at_top;
   logic             load;
   logic [N_EV-1:0]  ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q    <= '0;
         act_q    <= '0;
         run_q    <= 1'b0;
         ld_top_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADR_TOP)) top_q <= wr_data;
         if (wr_addr == ADDR_W'(ADR_ACT)) act_q <= wr_data[ACT_W-1:0];
         if (wr_addr == ADDR_W'(ADR_CTRL)) begin
            run_q    <= wr_data[0];
            ld_top_q <= wr_data[1];
         end
      end
   end

   pwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .top     (top_q),
      .cnt     (cnt),
      .up      (up),
      .at_zero (at_zero),
      .at_top  (at_top)
   );

   assign load = ld_top_q ? at_top : at_zero;

   assign ev[EV_ZERO] = run_q && at_zero;
   assign ev[EV_TOP]  = run_q && at_top;

   for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
      pwm_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (wr_en && wr_addr == ADDR_W'(ADR_CMP0 + g)),
         .wdata (wr_data),
         .load  (load),
         .run   (run_q),
         .up    (up),
         .cnt   (cnt),
         .top   (top_q),
         .ev_up (ev[EV_AU + 2*g]),
         .ev_dn (ev[EV_AD + 2*g])
      );
   end

   pwm_act_qual u_aq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .act_word (act_q),
      .pwm_out  (pwm_out)
   );

   AST_RUN_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q) |=> $stable(pwm_out)); // R10
   AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && act_q == ACT_W'(12'h060) && $stable(top_q) && pwm_out
       && g_cmp[0].u_cmp.work_q == top_q && cnt != top_q) |=> pwm_out); // R4

endmodule

// File: tb/updn_pwm_tb.sv
`timescale 1ns/1ps
module updn_pwm_tb;

   localparam int CW = 16;
   localparam int AW = 3;
   localparam int NV = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          pwm_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   int hi_run = 0;
   int last_w = 0;

   always #4 clk = ~clk;

   updn_pwm #(.CNT_W(CW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_out(pwm_out)
   );

   // vectors: top, cmpA, cmpB, action word, expected high clocks per cycle
   localparam int V_TOP [NV] = '{10, 10, 10, 10,  7,  8,  8,  6, 10,  5};
   localparam int V_CA  [NV] = '{ 4, 10,  0, 12,  1,  0,  0,  6,  3,  2};
   localparam int V_CB  [NV] = '{65535,65535,65535,65535,65535,65535,65535,65535,3,65535};
   localparam int V_ACT [NV] = '{'h060,'h060,'h060,'h060,'h060,'h006,'h00F,'h024,'h960,'hF060};
   localparam int V_EXP [NV] = '{12, 20,  0,  0, 12,  8,  8, 12,  6,  6};
   // tags: R11, R4, R5, R7, R11, R3, R2, R9, R9, R3 (upper bits ignored)
   localparam int V_REQ [NV] = '{11,  4,  5,  7, 11,  3,  2,  9,  9,  3};

   always @(negedge clk) begin
      if (pwm_out) hi_run++;
      else if (hi_run != 0) begin
         last_w = hi_run;
         hi_run = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int adr, input int dat);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = AW'(adr);
      wr_data = CW'(dat);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_level(input bit lvl);
      do @(negedge clk); while (pwm_out != lvl);
   endtask

   task automatic setup(input int top, input int ca, input int cb, input int act);
      wr(4, 0);
      wr(0, top);
      wr(1, ca);
      wr(2, cb);
      wr(3, act);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int hc;
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pwm_out == 1'b0, "R10 reset output", pwm_out, 0);

      // R6: start with counter and compare A at zero
      setup(10, 0, 65535, 'h060);
      chk(pwm_out == 1'b0, "R6 idle before start", pwm_out, 0);
      wr(4, 1);
      chk(pwm_out == 1'b0, "R6 not yet high", pwm_out, 0);
      @(negedge clk);
      chk(pwm_out == 1'b1, "R6 high on first running clock", pwm_out, 1);

      // table walk (R1 period length underlies every count)
      for (int i = 0; i < NV; i++) begin
         setup(V_TOP[i], V_CA[i], V_CB[i], V_ACT[i]);
         wr(4, 1);
         repeat (4 * V_TOP[i] + 3) @(negedge clk);
         hc = 0;
         for (int k = 0; k < 2 * V_TOP[i]; k++) begin
            @(negedge clk);
            if (pwm_out) hc++;
         end
         chk(hc == V_EXP[i], $sformatf("R%0d vector %0d duty", V_REQ[i], i), hc, V_EXP[i]);
      end

      // R10: stop while high, output holds
      setup(10, 4, 65535, 'h060);
      wr(4, 1);
      wait_level(1'b0);
      wait_level(1'b1);
      wr(4, 0);
      v = pwm_out;
      repeat (25) @(negedge clk);
      chk(pwm_out == 1'b1 && v == 1, "R10 output holds while stopped", pwm_out, 1);

      // R8: reload at top, compare changed 4 -> 8 mid pulse
      setup(10, 4, 65535, 'h060);
      wr(4, 3);
      repeat (45) @(negedge clk);
      wait_level(1'b0);
      wait_level(1'b1);
      wr(1, 8);
      wait_level(1'b0);
      repeat (3) @(negedge clk);
      chk(last_w == 8, "R8 top reload takes effect on falling slope", last_w, 8);
      wait_level(1'b1);
      wait_level(1'b0);
      repeat (3) @(negedge clk);
      chk(last_w == 4, "R8 new compare steady", last_w, 4);

      // R8: reload at zero, same change
      setup(10, 4, 65535, 'h060);
      wr(4, 1);
      repeat (45) @(negedge clk);
      wait_level(1'b0);
      wait_level(1'b1);
      wr(1, 8);
      wait_level(1'b0);
      repeat (3) @(negedge clk);
      chk(last_w == 12, "R8 zero reload keeps old compare", last_w, 12);
      wait_level(1'b1);
      wait_level(1'b0);
      repeat (3) @(negedge clk);
      chk(last_w == 4, "R8 zero reload applied next cycle", last_w, 4);

      // R12: writes to compare B do not disturb compare A
      setup(10, 4, 65535, 'h060);
      wr(4, 1);
      wr(2, 5);
      repeat (45) @(negedge clk);
      hc = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (pwm_out) hc++;
      end
      chk(hc == 12, "R12 address map separates compares", hc, 12);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule